// File: doc/BRIEF.md
# Bit-Split Reconfigurable Dot-Product Unit

This unit forms a signed dot product on an array of narrow multipliers, each taking an 8-bit activation and a 4-bit weight nibble. A mode input chosen with every transaction picks one of two operations. In narrow mode every multiplier contributes one 8×4 term. In wide mode the multipliers work in adjacent pairs. Each pair forms one full 8×8 product by multiplying one activation by the low and the high nibble of an 8-bit weight.

The products of the even lanes feed one adder tree and those of the odd lanes feed a second one. A single shift sits at the output of the odd-lane tree. In wide mode it moves the high-nibble partial sum up by four bit positions before the two tree sums are added. In narrow mode the two sums are added unshifted. A per-lane sign bit says whether each weight nibble is signed or unsigned.

The result is a registered signed partial sum with a valid flag two cycles after the input. It is meant to feed an external accumulator.

Top module: `nibbleDotUnit`

## Requirements
- R1: While reset is held and right after it, `outValid` is 0 and `sumOut` is 0.
- R2: An input accepted with `inValid`=1 at a rising edge produces `outValid`=1 with its result after exactly the second rising edge. `outValid` is 0 in every other cycle.
- R3: Narrow mode (`modeWide`=0): `sumOut` = Σ over lanes i of A_i × W_i. A_i is the signed two's-complement byte `actIn[8i+7:8i]`. W_i is the nibble `wgtIn[4i+3:4i]`, read as signed (-8..7) when `signCtl[i]`=1 and as unsigned (0..15) otherwise.
- R4: Wide mode (`modeWide`=1): `sumOut` = Σ over pairs k of A_2k × B_k with B_k = {`wgtIn` nibble 2k+1, `wgtIn` nibble 2k}. The high nibble is signed when `signCtl[2k+1]`=1, which makes B_k a signed byte (-128..127); otherwise B_k is unsigned (0..255). The low nibble is always unsigned.
- R5: In wide mode the odd-lane activations and the even-lane sign bits have no effect on the result.
- R6: `sumOut` keeps its value in every cycle where `outValid` is 0, whatever the inputs do while `inValid` is 0.
- R7: The mode travels with its data. Back-to-back inputs in different modes each produce the result of their own mode, one per cycle.
- R8: Full-scale operands give exact results without wrap-around: 16384 and -30720 in narrow mode, 131072 and -261120 in wide mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input operands valid this cycle |
| modeWide | input | 1 | 1 = paired 8×8 mode, 0 = 8×4 mode |
| signCtl | input | NUM_MULT | Per-lane weight-nibble signed flag |
| actIn | input | NUM_MULT*8 | Packed signed activations, lane i at bits [8i+7:8i] |
| wgtIn | input | NUM_MULT*4 | Packed weight nibbles, lane i at bits [4i+3:4i] |
| outValid | output | 1 | Result valid |
| sumOut | output | OUT_W (21) | Signed dot-product result |

## Verification
The bench goes after nibble signedness. A unit that sign-extended an unsigned nibble would turn weight 15 into -1, and one that treated the low nibble of a wide operand as signed would be off by 16 per product whenever bit 3 is set. It checks the shift placement: a missing or misplaced shift in wide mode scales the high partial sum wrongly, and a shift left active in narrow mode makes odd-lane products 16 times too large. Mixed-mode back-to-back traffic exposes a mode bit that is not pipelined with its data. Full-scale operands expose a sum that is too narrow and wraps. Wide-mode runs with odd-lane activations and even-lane sign bits changed expose lanes that are not rerouted.

// File: rtl/nibbleDotPkg.sv
package nibbleDotPkg;
  // Strobes from the control section to the datapath.
  typedef struct packed {
    logic s1Load;   // capture lane products
    logic s2Load;   // capture final sum
    logic s2Wide;   // stage-two mode: apply high-nibble shift
  } dpStrobe_t;
endpackage

// File: rtl/dotMulLane.sv
module dotMulLane #(
  parameter int ACT_W = 8,
  parameter int WGT_W = 4,
  localparam int PROD_W = ACT_W + WGT_W + 1
) (
  input  logic [ACT_W-1:0]         actVal,
  input  logic [WGT_W-1:0]         nibVal,
  input  logic                     nibSigned,
  output logic signed [PROD_W-1:0] prod
);
  // Nibble widened by one bit: sign bit only when marked signed.
  logic signed [WGT_W:0] nibExt;
  assign nibExt = {nibSigned & nibVal[WGT_W-1], nibVal};
  assign prod = $signed(actVal) * nibExt;
endmodule

// File: rtl/dotAddTree.sv
module dotAddTree #(
  parameter int N     = 8,
  parameter int IN_W  = 13,
  parameter int SUM_W = 16
) (
  input  logic signed [IN_W-1:0]  terms [N],
  output logic signed [SUM_W-1:0] sum
);
  always_comb begin
    sum = '0;
    for (int i = 0; i < N; i++) begin
      sum = sum + SUM_W'(terms[i]);
    end
  end
endmodule

// File: rtl/dotCtl.sv
module dotCtl
  import nibbleDotPkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      inValid,
  input  logic      modeWide,
  output dpStrobe_t strobe,
  output logic      outValid
);
  logic validS1;
  logic wideS1;
  logic validS2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      validS1 <= 1'b0;
      wideS1  <= 1'b0;
      validS2 <= 1'b0;
    end else begin
      validS1 <= inValid;
      validS2 <= validS1;
      if (inValid) wideS1 <= modeWide;
    end
  end

  always_comb begin
    strobe.s1Load = inValid;
    strobe.s2Load = validS1;
    strobe.s2Wide = wideS1;
  end

  assign outValid = validS2;
endmodule

// File: rtl/dotDatapath.sv
module dotDatapath
  import nibbleDotPkg::*;
#(
  parameter int NUM_MULT = 16,
  parameter int ACT_W    = 8,
  parameter int WGT_W    = 4,
  localparam int PAIRS  = NUM_MULT / 2,
  localparam int PROD_W = ACT_W + WGT_W + 1,
  localparam int TREE_W = PROD_W + $clog2(PAIRS),
  localparam int OUT_W  = TREE_W + WGT_W + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  dpStrobe_t                 strobe,
  input  logic                      modeWide,
  input  logic [NUM_MULT-1:0]       signCtl,
  input  logic [NUM_MULT*ACT_W-1:0] actIn,
  input  logic [NUM_MULT*WGT_W-1:0] wgtIn,
  output logic signed [OUT_W-1:0]   sumOut
);
  logic signed [PROD_W-1:0] prodLo  [PAIRS];
  logic signed [PROD_W-1:0] prodHi  [PAIRS];
  logic signed [PROD_W-1:0] prodLoQ [PAIRS];
  logic signed [PROD_W-1:0] prodHiQ [PAIRS];

  // Lane pairs: even lane carries the low nibble, odd lane the high nibble.
  for (genvar k = 0; k < PAIRS; k++) begin : g_pair
    logic [ACT_W-1:0] actLo;
    logic [ACT_W-1:0] actHi;
    logic             sgnLo;
    logic             sgnHi;

    assign actLo = actIn[(2*k)*ACT_W +: ACT_W];
    // Wide mode reuses the even activation for the high nibble.
    assign actHi = modeWide ? actIn[(2*k)*ACT_W +: ACT_W]
                            : actIn[(2*k+1)*ACT_W +: ACT_W];
    assign sgnLo = modeWide ? 1'b0 : signCtl[2*k];
    assign sgnHi = signCtl[2*k+1];

    dotMulLane #(.ACT_W(ACT_W), .WGT_W(WGT_W)) u_lo (
      .actVal   (actLo),
      .nibVal   (wgtIn[(2*k)*WGT_W +: WGT_W]),
      .nibSigned(sgnLo),
      .prod     (prodLo[k])
    );

    dotMulLane #(.ACT_W(ACT_W), .WGT_W(WGT_W)) u_hi (
      .actVal   (actHi),
      .nibVal   (wgtIn[(2*k+1)*WGT_W +: WGT_W]),
      .nibSigned(sgnHi),
      .prod     (prodHi[k])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prodLoQ[k] <= '0;
        prodHiQ[k] <= '0;
      end else if (strobe.s1Load) begin
        prodLoQ[k] <= prodLo[k];
        prodHiQ[k] <= prodHi[k];
      end
    end
  end

  logic signed [TREE_W-1:0] sumLo;
  logic signed [TREE_W-1:0] sumHi;

  dotAddTree #(.N(PAIRS), .IN_W(PROD_W), .SUM_W(TREE_W)) u_treeLo (
    .terms(prodLoQ),
    .sum  (sumLo)
  );

  dotAddTree #(.N(PAIRS), .IN_W(PROD_W), .SUM_W(TREE_W)) u_treeHi (
    .terms(prodHiQ),
    .sum  (sumHi)
  );

  // Single alignment shift after the high tree.
  logic signed [OUT_W-1:0] hiExt;
  logic signed [OUT_W-1:0] loExt;
  logic signed [OUT_W-1:0] hiAligned;
  logic signed [OUT_W-1:0] combined;

  always_comb begin
    hiExt     = OUT_W'(sumHi);
    loExt     = OUT_W'(sumLo);
    hiAligned = strobe.s2Wide ? (hiExt <<< WGT_W) : hiExt;
    combined  = hiAligned + loExt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sumOut <= '0;
    end else if (strobe.s2Load) begin
      sumOut <= combined;
    end
  end
endmodule

// File: rtl/nibbleDotUnit.sv
module nibbleDotUnit
  import nibbleDotPkg::*;
#(
  parameter int NUM_MULT = 16,
  parameter int ACT_W    = 8,
  parameter int WGT_W    = 4,
  localparam int OUT_W = ACT_W + WGT_W + 1 + $clog2(NUM_MULT / 2) + WGT_W + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      inValid,
  input  logic                      modeWide,
  input  logic [NUM_MULT-1:0]       signCtl,
  input  logic [NUM_MULT*ACT_W-1:0] actIn,
  input  logic [NUM_MULT*WGT_W-1:0] wgtIn,
  output logic                      outValid,
  output logic [OUT_W-1:0]          sumOut
);
  dpStrobe_t strobe;
  logic signed [OUT_W-1:0] sumRaw;

  dotCtl u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .inValid (inValid),
    .modeWide(modeWide),
    .strobe  (strobe),
    .outValid(outValid)
  );

  dotDatapath #(.NUM_MULT(NUM_MULT), .ACT_W(ACT_W), .WGT_W(WGT_W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .modeWide(modeWide),
    .signCtl (signCtl),
    .actIn   (actIn),
    .wgtIn   (wgtIn),
    .sumOut  (sumRaw)
  );

  assign sumOut = sumRaw;
endmodule

// File: rtl/nibbleDotCheck.sv
module nibbleDotCheck #(
  parameter int NUM_MULT = 16,
  parameter int WGT_W    = 4,
  parameter int OUT_W    = 21
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      inValid,
  input logic [NUM_MULT*WGT_W-1:0] wgtIn,
  input logic                      outValid,
  input logic [OUT_W-1:0]          sumOut
);
  // R1: reset empties the output
  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (!outValid && sumOut == '0));

  // R2: valid appears exactly two edges after an accepted input
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $past(inValid, 2) |-> outValid);

  // R2: no valid without an input two edges earlier
  a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(inValid, 2) |-> !outValid);

  // R6: result is held while no new result is flagged
  a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !outValid |-> $stable(sumOut));

  // R3, R4: all-zero weights give a zero sum in either mode
  a_r3_zero_weights: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(inValid, 2) && $past(wgtIn, 2) == '0) |-> sumOut == '0);
endmodule

bind nibbleDotUnit nibbleDotCheck #(
  .NUM_MULT(NUM_MULT),
  .WGT_W   (WGT_W),
  .OUT_W   (OUT_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .inValid (inValid),
  .wgtIn   (wgtIn),
  .outValid(outValid),
  .sumOut  (sumOut)
);

// File: tb/nibbleDotUnit_tb_top.sv
module nibbleDotUnit_tb_top;
  localparam int CLK_P = 10;
  localparam int NM    = 16;
  localparam int OW    = 21;
  localparam int NV    = 6;

  // Vector layout: {wide, signCtl[15:0], wgtIn[63:0], actIn[127:0]}
  localparam logic [208:0] VEC [NV] = '{
    {1'b0, 16'hFFFF, 64'h0123456789ABCDEF, 128'h00112233445566778899AABBCCDDEEFF},
    {1'b0, 16'h0000, 64'h0123456789ABCDEF, 128'h00112233445566778899AABBCCDDEEFF},
    {1'b0, 16'hA5A5, 64'hFEDCBA9876543210, 128'h7F80017F80FF00FE0102030405060708},
    {1'b1, 16'hAAAA, 64'h8F7F01FF80A55A3C, 128'h80FF7F01123456789ABCDEF011223344},
    {1'b1, 16'h0000, 64'h8F7F01FF80A55A3C, 128'h80FF7F01123456789ABCDEF011223344},
    {1'b1, 16'hFFFF, 64'hC3E1970F28B46D5A, 128'h7F80FF0180017FFE0C9AE2441B66F0D3}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inValid = 1'b0;
  logic modeWide = 1'b0;
  logic [NM-1:0] signCtl = '0;
  logic [NM*8-1:0] actIn = '0;
  logic [NM*4-1:0] wgtIn = '0;
  logic outValid;
  logic [OW-1:0] sumOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  nibbleDotUnit dut_i (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .modeWide(modeWide),
    .signCtl(signCtl), .actIn(actIn), .wgtIn(wgtIn),
    .outValid(outValid), .sumOut(sumOut)
  );

  // Reference from the requirement text (R3, R4).
  function automatic int model(input logic [208:0] v);
    int acc = 0;
    logic wide = v[208];
    logic [15:0] sg = v[207:192];
    logic [63:0] wg = v[191:128];
    logic [127:0] ac = v[127:0];
    if (!wide) begin
      for (int i = 0; i < NM; i++) begin
        int a = int'($signed(ac[8*i +: 8]));
        int w = sg[i] ? int'($signed(wg[4*i +: 4])) : int'(wg[4*i +: 4]);
        acc += a * w;
      end
    end else begin
      for (int k = 0; k < NM/2; k++) begin
        int a  = int'($signed(ac[16*k +: 8]));
        int hi = sg[2*k+1] ? int'($signed(wg[8*k+4 +: 4])) : int'(wg[8*k+4 +: 4]);
        int b  = hi * 16 + int'(wg[8*k +: 4]);
        acc += a * b;
      end
    end
    return acc;
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic drive(input logic [208:0] v);
    modeWide = v[208];
    signCtl  = v[207:192];
    wgtIn    = v[191:128];
    actIn    = v[127:0];
    inValid  = 1'b1;
  endtask

  // One isolated transaction; also checks R2 latency.
  task automatic runOne(input string tag, input logic [208:0] v, input int exp);
    @(negedge clk);
    drive(v);
    @(negedge clk);
    inValid = 1'b0;
    check({tag, " R2 no valid after one edge"}, int'(outValid), 0);
    @(negedge clk);
    check({tag, " R2 valid after two edges"}, int'(outValid), 1);
    check(tag, int'($signed(sumOut)), exp);
    @(negedge clk);
    check({tag, " R2 valid single cycle"}, int'(outValid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seq [4] = '{0, 3, 1, 4};
    int held;
    logic [208:0] alt;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 outValid in reset", int'(outValid), 0);
    check("R1 sumOut in reset", int'(sumOut), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 outValid after reset", int'(outValid), 0);
    check("R1 sumOut after reset", int'(sumOut), 0);

    // Table walk: R3 narrow, R4 wide
    for (int n = 0; n < NV; n++) begin
      runOne(VEC[n][208] ? "R4 wide vector" : "R3 narrow vector", VEC[n], model(VEC[n]));
    end

    // R7: back-to-back mixed modes
    for (int t = 0; t < 6; t++) begin
      @(negedge clk);
      if (t >= 2) begin
        check("R7 b2b valid", int'(outValid), 1);
        check("R7 b2b mixed-mode sum", int'($signed(sumOut)), model(VEC[seq[t-2]]));
      end
      if (t < 4) drive(VEC[seq[t]]);
      else inValid = 1'b0;
    end
    @(negedge clk);
    check("R7 b2b valid drops", int'(outValid), 0);

    // R6: inputs toggle without inValid; output must hold
    held = int'($signed(sumOut));
    for (int t = 0; t < 4; t++) begin
      @(negedge clk);
      modeWide = ~modeWide;
      signCtl  = ~signCtl;
      wgtIn    = {wgtIn[59:0], wgtIn[63:60]} ^ 64'h5A5A5A5A5A5A5A5A;
      actIn    = ~actIn;
      check("R6 no valid while idle", int'(outValid), 0);
      check("R6 sum held while idle", int'($signed(sumOut)), held);
    end

    // R5: odd activations and even sign bits ignored in wide mode
    alt = VEC[5];
    for (int k = 0; k < NM/2; k++) begin
      alt[16*k+8 +: 8] = ~alt[16*k+8 +: 8];
      alt[192 + 2*k]   = ~alt[192 + 2*k];
    end
    runOne("R5 wide ignores odd act and even sign", alt, model(VEC[5]));

    // R8: full-scale operands (hand-computed values)
    runOne("R8 narrow -128*-8", {1'b0, 16'hFFFF, {16{4'h8}}, {16{8'h80}}}, 16384);
    runOne("R8 narrow -128*15", {1'b0, 16'h0000, {16{4'hF}}, {16{8'h80}}}, -30720);
    runOne("R8 wide -128*-128", {1'b1, 16'hAAAA, {8{8'h80}}, {16{8'h80}}}, 131072);
    runOne("R8 wide -128*255",  {1'b1, 16'h0000, {8{8'hFF}}, {16{8'h80}}}, -261120);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule